// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block is the processor-facing side of a floppy disk controller. A host reaches five registers through an 8-bit data path, an active-low chip select, separate active-low read and write strobes and a 2-bit register address. The command, track, sector and data registers and a status view live here. The block raises the data-request and interrupt-request lines, and it flags lost data when the serial byte engine outruns the host in either direction. It also applies the power-on defaults and starts the initial restore.

The host strobes are asynchronous to the controller clock. They are passed through a synchronizer. A register write takes effect once the write strobe is released. Side effects of a read, such as clearing the interrupt or the data request, happen once per read strobe, when it ends. The disk-side sequencer receives the accepted command code and a one-cycle start pulse. It returns a busy level and a one-cycle done pulse. The serial engine signals a finished incoming byte with a strobe, and asks for the next outgoing byte with a request.

Top module: `fdc_host_regs`

## Requirements
- R1: With chip select low, address 2'b01 reads and writes the track register, 2'b10 the sector register and 2'b11 the data register. Address 2'b00 writes the command register and reads the status view. A write to 2'b00 never loads the status view, and the command register is never returned on the data bus.
- R2: Status bit 0 is the busy input and bit 7 is the inverse of drive ready. Bit 1 (data request) and bit 2 (lost data) appear only when the last accepted non-force command has bit 7 set. Bits 3 to 6 read zero.
- R3: While reset is low, the command register holds 8'h03 and status bit 7 reads 0. After release, the sector register reads 8'h01 and the track register reads 8'h00. Exactly one start pulse with command 8'h03 is issued, regardless of drive ready.
- R4: An incoming-byte strobe loads the data register and sets the data request. A host read of the data register clears it.
- R5: An incoming-byte strobe that arrives while the data request is still set overwrites the data register and sets lost data.
- R6: The sequencer arm pulse sets the data request, and a host write of the data register clears it. A byte request from the engine moves the data register to the outgoing byte and sets the data request.
- R7: A byte request that arrives while the data request is still set sends 8'h00 and sets lost data.
- R8: A done pulse sets the interrupt request. A status read clears it, and so does any command write, including one that is then ignored.
- R9: A command written while busy is ignored, with no change to the command code and no start pulse, unless its upper nibble is 4'hD. Such a force command is accepted and started.
- R10: Writes take effect only after the write strobe ends. The side effects of a read happen once, after the read strobe ends, however long the strobe is held.
- R11: An accepted non-force command clears the data request and lost data. An accepted force command leaves both, and the status view, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Master reset, active low |
| cs_n | input | 1 | Host chip select, active low |
| re_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, zero when not reading |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| cmd_code | output | 8 | Command register to the sequencer |
| cmd_start | output | 1 | One-cycle pulse when a command is accepted |
| trk_reg | output | 8 | Track register to the sequencer |
| sec_reg | output | 8 | Sector register to the sequencer |
| seq_busy | input | 1 | Sequencer busy level |
| seq_done | input | 1 | One-cycle command completion pulse |
| seq_drq_arm | input | 1 | One-cycle pulse requesting the first write byte |
| drive_rdy | input | 1 | Drive ready level |
| eng_rd_stb | input | 1 | One-cycle pulse: an incoming byte is assembled |
| eng_rd_byte | input | 8 | Incoming byte, valid with eng_rd_stb |
| eng_wr_req | input | 1 | One-cycle pulse: the engine needs the next byte |
| eng_wr_byte | output | 8 | Outgoing byte, updated after each eng_wr_req |

## Verification
The properties assume that the sequencer and engine pulses last a single cycle and that an engine strobe never lands in the same cycle as the synchronized end of a host access. They also assume the host holds address and data steady for the whole strobe and a few cycles after it. The bench meets these assumptions. It drives every input on the falling clock edge and holds each host strobe for several cycles, which is longer than the synchronizer depth. It then waits out the synchronizer before the next access. It fires engine and sequencer pulses only while the host bus is idle.

// File: rtl/fdc_hr_pkg.sv
package fdc_hr_pkg;

    typedef enum logic [1:0] {
        RA_CMDSTAT = 2'b00,
        RA_TRACK   = 2'b01,
        RA_SECTOR  = 2'b10,
        RA_DATA    = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic re_n;
    } strobe_t;

    localparam logic [7:0] CMD_BOOT  = 8'h03;
    localparam logic [7:0] SEC_BOOT  = 8'h01;
    localparam logic [7:0] TRK_BOOT  = 8'h00;
    localparam logic [3:0] FORCE_NIB = 4'hD;

    localparam int ST_BUSY = 0;
    localparam int ST_DRQ  = 1;
    localparam int ST_LOST = 2;
    localparam int ST_NRDY = 7;

endpackage

// File: rtl/fdc_hr_sync.sv
module fdc_hr_sync
    import fdc_hr_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int DW     = 8,
    parameter int AW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          re_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_pulse,
    output logic [AW-1:0] rd_addr
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        strobe_t [STAGES-1:0] pipe;
        logic                 wr_act;
        logic                 rd_act;
        logic [AW-1:0]        wa;
        logic [AW-1:0]        ra;
        logic [DW-1:0]        wd;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     wr_now, rd_now, wr_early, rd_early;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = '{cs_n: cs_n, we_n: we_n, re_n: re_n};
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        wr_early = ~st_q.pipe[0].cs_n & ~st_q.pipe[0].we_n;
        rd_early = ~st_q.pipe[0].cs_n & ~st_q.pipe[0].re_n;
        wr_now   = ~st_q.pipe[LAST].cs_n & ~st_q.pipe[LAST].we_n;
        rd_now   = ~st_q.pipe[LAST].cs_n & ~st_q.pipe[LAST].re_n;
        if (wr_early) begin
            st_d.wa = addr;
            st_d.wd = din;
        end
        if (rd_early) begin
            st_d.ra = addr;
        end
        st_d.wr_act = wr_now;
        st_d.rd_act = rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pipe: '1, wr_act: 1'b0, rd_act: 1'b0,
                      wa: '0, ra: '0, wd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_pulse = st_q.wr_act & ~wr_now;
    assign rd_pulse = st_q.rd_act & ~rd_now;
    assign wr_addr  = st_q.wa;
    assign wr_data  = st_q.wd;
    assign rd_addr  = st_q.ra;

endmodule

// File: rtl/fdc_hr_xfer.sv
module fdc_hr_xfer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          arm,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          eng_rd_stb,
    input  logic [DW-1:0] eng_rd_byte,
    input  logic          eng_wr_req,
    output logic [DW-1:0] dr,
    output logic          drq,
    output logic          lost,
    output logic [DW-1:0] eng_wr_byte
);

    typedef struct packed {
        logic [DW-1:0] dr;
        logic [DW-1:0] wb;
        logic          drq;
        logic          lost;
    } xfer_st_t;

    xfer_st_t xf_d, xf_q;

    always_comb begin
        xf_d = xf_q;
        if (clr) begin
            xf_d.drq  = 1'b0;
            xf_d.lost = 1'b0;
        end
        if (host_wr) begin
            xf_d.dr  = host_wdata;
            xf_d.drq = 1'b0;
        end
        if (host_rd) begin
            xf_d.drq = 1'b0;
        end
        if (arm) begin
            xf_d.drq = 1'b1;
        end
        if (eng_rd_stb) begin
            if (xf_q.drq) begin
                xf_d.lost = 1'b1;
            end
            xf_d.dr  = eng_rd_byte;
            xf_d.drq = 1'b1;
        end
        if (eng_wr_req) begin
            if (xf_q.drq) begin
                xf_d.wb   = '0;
                xf_d.lost = 1'b1;
            end else begin
                xf_d.wb = xf_q.dr;
            end
            xf_d.drq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xf_q <= '0;
        end else begin
            xf_q <= xf_d;
        end
    end

    assign dr          = xf_q.dr;
    assign drq         = xf_q.drq;
    assign lost        = xf_q.lost;
    assign eng_wr_byte = xf_q.wb;

endmodule

// File: rtl/fdc_hr_cmd.sv
module fdc_hr_cmd
    import fdc_hr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_data,
    input  logic          stat_rd,
    input  logic          seq_busy,
    input  logic          seq_done,
    output logic [DW-1:0] cmd_code,
    output logic          cmd_start,
    output logic          xfer_mode,
    output logic          intrq,
    output logic          clr_xfer
);

    localparam int NIB_LO = DW - 4;

    typedef struct packed {
        logic [DW-1:0] cmd;
        logic          start;
        logic          boot;
        logic          xmode;
        logic          irq;
    } cmd_st_t;

    cmd_st_t cm_d, cm_q;
    logic    is_force, accept;

    always_comb begin
        is_force = (cmd_data[DW-1:NIB_LO] == FORCE_NIB);
        accept   = cmd_wr & (~seq_busy | is_force);
        cm_d       = cm_q;
        cm_d.start = 1'b0;
        if (cm_q.boot) begin
            cm_d.boot  = 1'b0;
            cm_d.start = 1'b1;
        end
        if (cmd_wr) begin
            cm_d.irq = 1'b0;
        end
        if (accept) begin
            cm_d.cmd   = cmd_data;
            cm_d.start = 1'b1;
            if (!is_force) begin
                cm_d.xmode = cmd_data[DW-1];
            end
        end
        if (stat_rd) begin
            cm_d.irq = 1'b0;
        end
        if (seq_done) begin
            cm_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q <= '{cmd: DW'(CMD_BOOT), start: 1'b0, boot: 1'b1,
                      xmode: 1'b0, irq: 1'b0};
        end else begin
            cm_q <= cm_d;
        end
    end

    assign cmd_code  = cm_q.cmd;
    assign cmd_start = cm_q.start;
    assign xfer_mode = cm_q.xmode;
    assign intrq     = cm_q.irq;
    assign clr_xfer  = accept & ~is_force;

endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_hr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          re_n,
    input  logic          we_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          drq,
    output logic          intrq,
    output logic [DW-1:0] cmd_code,
    output logic          cmd_start,
    output logic [DW-1:0] trk_reg,
    output logic [DW-1:0] sec_reg,
    input  logic          seq_busy,
    input  logic          seq_done,
    input  logic          seq_drq_arm,
    input  logic          drive_rdy,
    input  logic          eng_rd_stb,
    input  logic [DW-1:0] eng_rd_byte,
    input  logic          eng_wr_req,
    output logic [DW-1:0] eng_wr_byte
);

    localparam int AW = 2;

    typedef struct packed {
        logic [DW-1:0] trk;
        logic [DW-1:0] sec;
    } rf_st_t;

    rf_st_t        rf_d, rf_q;
    logic          wr_pulse, rd_pulse;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data;
    logic          cmd_wr, stat_rd, dr_wr, dr_rd;
    logic          xfer_mode, clr_xfer, lost;
    logic [DW-1:0] dr;
    logic [DW-1:0] status;

    fdc_hr_sync #(.STAGES(SYNC_STAGES), .DW(DW), .AW(AW)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .re_n    (re_n),
        .addr    (addr),
        .din     (din),
        .wr_pulse(wr_pulse),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_pulse(rd_pulse),
        .rd_addr (rd_addr)
    );

    always_comb begin
        cmd_wr  = wr_pulse & (reg_addr_e'(wr_addr) == RA_CMDSTAT);
        dr_wr   = wr_pulse & (reg_addr_e'(wr_addr) == RA_DATA);
        stat_rd = rd_pulse & (reg_addr_e'(rd_addr) == RA_CMDSTAT);
        dr_rd   = rd_pulse & (reg_addr_e'(rd_addr) == RA_DATA);
    end

    fdc_hr_cmd #(.DW(DW)) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_data (wr_data),
        .stat_rd  (stat_rd),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .cmd_code (cmd_code),
        .cmd_start(cmd_start),
        .xfer_mode(xfer_mode),
        .intrq    (intrq),
        .clr_xfer (clr_xfer)
    );

    fdc_hr_xfer #(.DW(DW)) xfer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_xfer),
        .arm        (seq_drq_arm),
        .host_wr    (dr_wr),
        .host_wdata (wr_data),
        .host_rd    (dr_rd),
        .eng_rd_stb (eng_rd_stb),
        .eng_rd_byte(eng_rd_byte),
        .eng_wr_req (eng_wr_req),
        .dr         (dr),
        .drq        (drq),
        .lost       (lost),
        .eng_wr_byte(eng_wr_byte)
    );

    always_comb begin
        rf_d = rf_q;
        if (wr_pulse) begin
            unique case (reg_addr_e'(wr_addr))
                RA_TRACK:  rf_d.trk = wr_data;
                RA_SECTOR: rf_d.sec = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '{trk: DW'(TRK_BOOT), sec: DW'(SEC_BOOT)};
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_BUSY] = seq_busy;
        status[ST_DRQ]  = drq & xfer_mode;
        status[ST_LOST] = lost & xfer_mode;
        status[ST_NRDY] = ~drive_rdy & rst_n;
    end

    always_comb begin
        dout = '0;
        if (!cs_n && !re_n) begin
            unique case (reg_addr_e'(addr))
                RA_CMDSTAT: dout = status;
                RA_TRACK:   dout = rf_q.trk;
                RA_SECTOR:  dout = rf_q.sec;
                RA_DATA:    dout = dr;
                default:    dout = '0;
            endcase
        end
    end

    assign trk_reg = rf_q.trk;
    assign sec_reg = rf_q.sec;

endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          re_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] dout,
    input logic          drq,
    input logic          intrq,
    input logic [DW-1:0] cmd_code,
    input logic          cmd_start,
    input logic          seq_done,
    input logic          eng_rd_stb,
    input logic          eng_wr_req,
    input logic [DW-1:0] eng_wr_byte
);

    // R8: completion always raises the interrupt
    a_r8_done_sets_intrq: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> intrq);

    // R4: an assembled byte always raises the data request
    a_r4_byte_sets_drq: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rd_stb |=> drq);

    // R7: an unserviced request sends a zero byte
    a_r7_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr_req && drq) |=> (eng_wr_byte == '0));

    // R2: unused status bits stay low
    a_r2_status_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !re_n && addr == 2'b00) |-> (dout[6:3] == 4'b0000));

    // R9: the command code only moves together with a start pulse
    a_r9_cmd_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code != $past(cmd_code)) |-> cmd_start);

endmodule

bind fdc_host_regs fdc_host_regs_chk #(.DW(DW)) chk_i (.*);

// File: tb/fdc_host_regs_tb_top.sv
module fdc_host_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, re_n, we_n;
    logic [1:0] addr;
    logic [7:0] din, dout;
    logic       drq, intrq, cmd_start;
    logic [7:0] cmd_code, trk_reg, sec_reg, eng_rd_byte, eng_wr_byte;
    logic       seq_busy, seq_done, seq_drq_arm, drive_rdy, eng_rd_stb, eng_wr_req;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    logic [7:0] last_cmd = 8'h00;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fdc_host_regs dut_i (.*);

    always @(posedge clk) begin
        if (rst_n && cmd_start) begin
            starts   = starts + 1;
            last_cmd = cmd_code;
        end
    end

    // {is_write, addr, data}; data on a read row is the expected value
    localparam logic [10:0] VEC [0:9] = '{
        {1'b1, 2'b01, 8'h22}, {1'b0, 2'b01, 8'h22},
        {1'b1, 2'b10, 8'h07}, {1'b0, 2'b10, 8'h07},
        {1'b1, 2'b11, 8'h5A}, {1'b0, 2'b11, 8'h5A},
        {1'b1, 2'b01, 8'hF4}, {1'b0, 2'b01, 8'hF4},
        {1'b0, 2'b10, 8'h07}, {1'b0, 2'b11, 8'h5A}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; cs_n = 1'b0; re_n = 1'b0;
        repeat (2) @(negedge clk);
        v = dout;
        @(negedge clk);
        cs_n = 1'b1; re_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse(input int which, input logic [7:0] b);
        @(negedge clk);
        eng_rd_byte = b;
        case (which)
            0: seq_done    = 1'b1;
            1: eng_rd_stb  = 1'b1;
            2: eng_wr_req  = 1'b1;
            default: seq_drq_arm = 1'b1;
        endcase
        @(negedge clk);
        seq_done = 1'b0; eng_rd_stb = 1'b0; eng_wr_req = 1'b0; seq_drq_arm = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; cs_n = 1'b0; re_n = 1'b0; we_n = 1'b1; addr = 2'b00; din = 8'h00;
        seq_busy = 1'b0; seq_done = 1'b0; seq_drq_arm = 1'b0; drive_rdy = 1'b0;
        eng_rd_stb = 1'b0; eng_rd_byte = 8'h00; eng_wr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 not-ready hidden in reset", dout, 8'h00);
        chk("R3 command default in reset", cmd_code, 8'h03);
        cs_n = 1'b1; re_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 one restore start", 8'(starts), 8'd1);
        chk("R3 restore code", last_cmd, 8'h03);
        host_rd(2'b10, v); chk("R3 sector default", v, 8'h01);
        host_rd(2'b01, v); chk("R3 track default", v, 8'h00);
        host_rd(2'b00, v); chk("R2 not-ready bit", v, 8'h80);
        drive_rdy = 1'b1;

        // R1 table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][10]) host_wr(VEC[i][9:8], VEC[i][7:0]);
            else begin
                host_rd(VEC[i][9:8], v);
                chk("R1 register map", v, VEC[i][7:0]);
            end
        end

        // R10 write not applied while strobe held
        @(negedge clk);
        addr = 2'b01; din = 8'h99; cs_n = 1'b0; we_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 write waits for strobe end", trk_reg, 8'hF4);
        cs_n = 1'b1; we_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 write lands after strobe", trk_reg, 8'h99);

        // R8 / R10 interrupt clear on status read
        pulse(0, 8'h00);
        chk("R8 done sets intrq", {7'b0, intrq}, 8'h01);
        @(negedge clk);
        addr = 2'b00; cs_n = 1'b0; re_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 intrq held during long read", {7'b0, intrq}, 8'h01);
        cs_n = 1'b1; re_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8 status read clears intrq", {7'b0, intrq}, 8'h00);

        // R1 / R8 command write
        pulse(0, 8'h00);
        host_wr(2'b00, 8'h10);
        chk("R8 command write clears intrq", {7'b0, intrq}, 8'h00);
        chk("R1 command register loaded", cmd_code, 8'h10);
        chk("R9 idle command starts", 8'(starts), 8'd2);
        host_rd(2'b00, v); chk("R1 status not loaded by write", v, 8'h00);

        // R9 busy rejection and force
        seq_busy = 1'b1;
        pulse(0, 8'h00);
        host_wr(2'b00, 8'h88);
        chk("R9 busy command ignored", cmd_code, 8'h10);
        chk("R9 no start when ignored", 8'(starts), 8'd2);
        chk("R8 ignored write clears intrq", {7'b0, intrq}, 8'h00);
        host_wr(2'b00, 8'hD0);
        chk("R9 force accepted", cmd_code, 8'hD0);
        chk("R9 force started", 8'(starts), 8'd3);
        seq_busy = 1'b0;

        // R4 / R5 read transfer
        host_wr(2'b00, 8'h80);
        seq_busy = 1'b1;
        host_rd(2'b00, v); chk("R2 busy bit", v, 8'h01);
        pulse(1, 8'hA5);
        chk("R4 byte sets drq", {7'b0, drq}, 8'h01);
        host_rd(2'b00, v); chk("R2 drq mirrored", v, 8'h03);
        host_rd(2'b11, v); chk("R4 data byte", v, 8'hA5);
        chk("R4 data read clears drq", {7'b0, drq}, 8'h00);
        pulse(1, 8'h11);
        pulse(1, 8'h22);
        host_rd(2'b00, v); chk("R5 overrun lost data", v, 8'h07);
        host_rd(2'b11, v); chk("R5 newest byte kept", v, 8'h22);

        // R11 force keeps, normal command clears
        host_wr(2'b00, 8'hD0);
        host_rd(2'b00, v); chk("R11 force keeps lost", v, 8'h05);
        seq_busy = 1'b0;
        host_wr(2'b00, 8'hA0);
        host_rd(2'b00, v); chk("R11 command clears lost", v, 8'h00);

        // R6 / R7 write transfer
        pulse(3, 8'h00);
        chk("R6 arm sets drq", {7'b0, drq}, 8'h01);
        host_wr(2'b11, 8'h3C);
        chk("R6 host load clears drq", {7'b0, drq}, 8'h00);
        pulse(2, 8'h00);
        chk("R6 byte handed to engine", eng_wr_byte, 8'h3C);
        chk("R6 request sets drq", {7'b0, drq}, 8'h01);
        pulse(2, 8'h00);
        chk("R7 underrun zero byte", eng_wr_byte, 8'h00);
        host_rd(2'b00, v); chk("R7 underrun lost data", v, 8'h06);

        // R2 masking for a command with bit 7 clear
        host_wr(2'b00, 8'h00);
        pulse(3, 8'h00);
        host_rd(2'b00, v); chk("R2 drq hidden for positioning command", v, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule